// File: doc/BRIEF.md
# 100 Mb/s Transmit Symbol Framer (4-bit to 5-bit)

This block sits between a media-access controller's nibble-wide transmit interface and the serializer of a 100 Mb/s line. On every nibble clock it produces one 5-bit code-group and a valid flag. While no frame is active it sends a continuous idle symbol. When transmit enable rises, the first two nibbles of preamble are dropped and a start delimiter pair is sent in their place. Every later nibble of the frame is translated through the fixed 4-to-5 table.

When transmit enable falls, the block appends an end delimiter pair and then goes back to idle fill. A transmit-error input, when it is built in, swaps the mapped data symbol for a halt symbol. Scrambling, serialization and line coding take place further down the path. The output is registered. The symbol for the inputs sampled at a clock edge appears right after that same edge.

Top module: `cg_tx_encoder`

## Requirements
- R1: While `rst` is high, `sym_vld` is 0 and `sym` is the idle code 11111 from the following edge on.
- R2: When no frame is active and `tx_en` is low, every edge emits idle 11111.
- R3: The first edge that samples `tx_en` high emits J (11000). The next edge emits K (10001). The nibble values sampled at those two edges are discarded.
- R4: After K, each edge that samples `tx_en` high emits the data code for `tx_nib`: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: The first edge after K or data that samples `tx_en` low emits T (01101). The next edge emits R (00111) whatever `tx_en` is.
- R6: After R, idle 11111 is emitted on every edge until `tx_en` is sampled high.
- R7: If `tx_en` is high again at the edge that emits R, R is still completed. J follows on the next edge if `tx_en` is still high.
- R8: With error support built in, `tx_er` high at an edge that would emit a data code emits H (00100) instead. `tx_er` has no effect on idle, J or K.
- R9: `sym_vld` is 1 after every edge that samples `rst` low.
- R10: If `tx_en` falls at the edge after J, K is still sent, followed by T and R.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Frame active strobe from the controller |
| tx_er | input | 1 | Transmit error strobe |
| tx_nib | input | NIB_W | Data nibble |
| sym | output | NIB_W+1 | Registered code-group |
| sym_vld | output | 1 | Code-group valid |

## Verification
The bench builds the block with its defaults, a 4-bit nibble and error support enabled. This brings the halt-symbol substitution and its masking during the delimiter symbols within reach. A reference model in the bench predicts every symbol from the sampled strobes. It drives all sixteen nibble values, a restart that lands on the R symbol, and a frame that ends right after J.

// File: rtl/cg_enc_pkg.sv
package cg_enc_pkg;

  localparam logic [4:0] CG_IDLE = 5'b11111;
  localparam logic [4:0] CG_J    = 5'b11000;
  localparam logic [4:0] CG_K    = 5'b10001;
  localparam logic [4:0] CG_T    = 5'b01101;
  localparam logic [4:0] CG_R    = 5'b00111;
  localparam logic [4:0] CG_H    = 5'b00100;

  // state names what was emitted on the most recent edge
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_J     = 3'd1,
    ST_K     = 3'd2,
    ST_DATA  = 3'd3,
    ST_T     = 3'd4,
    ST_R     = 3'd5
  } enc_st_t;

  function automatic logic [4:0] map_nib(input logic [3:0] n);
    logic [4:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cg_seq_fsm.sv
module cg_seq_fsm
  import cg_enc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tx_en,
  output enc_st_t st_q,
  output enc_st_t st_nxt
);

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE: st_nxt = tx_en ? ST_J : ST_IDLE;
      ST_J:    st_nxt = ST_K;
      ST_K,
      ST_DATA: st_nxt = tx_en ? ST_DATA : ST_T;
      ST_T:    st_nxt = ST_R;
      ST_R:    st_nxt = tx_en ? ST_J : ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_nxt;
  end

endmodule

// File: rtl/cg_sym_mux.sv
module cg_sym_mux
  import cg_enc_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter bit ERR_EN = 1'b1,
  localparam int SYM_W = NIB_W + 1
) (
  input  enc_st_t          st_nxt,
  input  logic [NIB_W-1:0] nib,
  input  logic             err,
  output logic [SYM_W-1:0] sym_d
);

  logic err_hit;

  generate
    if (ERR_EN) begin : g_err
      assign err_hit = err;
    end else begin : g_noerr
      logic unused_err;
      assign unused_err = err;
      assign err_hit    = 1'b0;
    end
  endgenerate

  always_comb begin
    case (st_nxt)
      ST_J:    sym_d = CG_J;
      ST_K:    sym_d = CG_K;
      ST_DATA: sym_d = err_hit ? CG_H : map_nib(nib);
      ST_T:    sym_d = CG_T;
      ST_R:    sym_d = CG_R;
      default: sym_d = CG_IDLE;
    endcase
  end

endmodule

// File: rtl/cg_out_stage.sv
module cg_out_stage
  import cg_enc_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] sym_d,
  output logic [SYM_W-1:0] sym_q,
  output logic             vld_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q <= CG_IDLE;
      vld_q <= 1'b0;
    end else begin
      sym_q <= sym_d;
      vld_q <= 1'b1;
    end
  end

endmodule

// File: rtl/cg_tx_encoder.sv
module cg_tx_encoder
  import cg_enc_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter bit ERR_EN = 1'b1,
  localparam int SYM_W = NIB_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] tx_nib,
  output logic [SYM_W-1:0] sym,
  output logic             sym_vld
);

  enc_st_t          st_q;
  enc_st_t          st_nxt;
  logic [SYM_W-1:0] sym_d;
  logic             body_w;   // frame body: next edge may carry data

  cg_seq_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en),
    .st_q   (st_q),
    .st_nxt (st_nxt)
  );

  cg_sym_mux #(.NIB_W(NIB_W), .ERR_EN(ERR_EN)) u_mux (
    .st_nxt (st_nxt),
    .nib    (tx_nib),
    .err    (tx_er),
    .sym_d  (sym_d)
  );

  cg_out_stage #(.SYM_W(SYM_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .sym_d (sym_d),
    .sym_q (sym),
    .vld_q (sym_vld)
  );

  assign body_w = (st_q == ST_K) || (st_q == ST_DATA);

endmodule

module cg_tx_encoder_chk
  import cg_enc_pkg::*;
#(
  parameter int SYM_W  = 5,
  parameter bit ERR_EN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_en,
  input logic             tx_er,
  input logic [SYM_W-1:0] sym,
  input logic             sym_vld,
  input logic             body_w
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sym_vld && sym == CG_IDLE));

  // R3
  j_then_k_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && sym == CG_J) |=> sym == CG_K);

  // R5
  t_then_r_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && sym == CG_T) |=> sym == CG_R);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && (sym == CG_R || sym == CG_IDLE) && !tx_en) |=> sym == CG_IDLE);

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_vld && sym == CG_R && tx_en) |=> sym == CG_J);

  // R8
  err_sym_chk: assert property (@(posedge clk) disable iff (rst)
    (ERR_EN && body_w && tx_en && tx_er) |=> sym == CG_H);

  // R9
  vld_on_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sym_vld);

endmodule

bind cg_tx_encoder cg_tx_encoder_chk #(.SYM_W(SYM_W), .ERR_EN(ERR_EN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_en   (tx_en),
  .tx_er   (tx_er),
  .sym     (sym),
  .sym_vld (sym_vld),
  .body_w  (body_w)
);

// File: tb/cg_tx_encoder_tb.sv
module cg_tx_encoder_tb;

  localparam int CLK_PER = 10;

  typedef struct {
    logic [4:0] code;
    string      req;
  } exp_t;

  localparam logic [4:0] TBL [16] = '{
    5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
    5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic [4:0] sym;
  logic       sym_vld;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  exp_t q[$];
  int   phase = 0;   // 0 quiet, 1 J sent, 2 body, 3 T sent

  always #(CLK_PER/2) clk = ~clk;

  cg_tx_encoder u_dut (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .tx_er   (tx_er),
    .tx_nib  (tx_nib),
    .sym     (sym),
    .sym_vld (sym_vld)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // driver: applies one nibble slot and predicts its code-group
  task automatic drive(input bit en, input logic [3:0] nib, input bit er, input string req);
    exp_t e;
    @(negedge clk);
    tx_en = en; tx_nib = nib; tx_er = er;
    e.req = req;
    case (phase)
      0: begin
        if (en) begin e.code = 5'b11000; phase = 1; end
        else    e.code = 5'b11111;
      end
      1: begin e.code = 5'b10001; phase = 2; end
      2: begin
        if (en) e.code = er ? 5'b00100 : TBL[nib];
        else begin e.code = 5'b01101; phase = 3; end
      end
      default: begin e.code = 5'b00111; phase = 0; end
    endcase
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, sym, e.code);
        check("R9", {4'b0, sym_vld}, 5'd1);
      end
    end
  end

  initial begin
    #(CLK_PER * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", sym, 5'b11111);
    check("R1", {4'b0, sym_vld}, 5'd0);
    @(negedge clk);
    rst = 1'b0;
    // R2 idle fill
    for (int i = 0; i < 4; i++) drive(0, 4'(i + 3), 0, "R2");
    // R3 delimiters replace preamble, R4 full table
    drive(1, 4'h5, 0, "R3");
    drive(1, 4'h5, 0, "R3");
    for (int i = 0; i < 16; i++) drive(1, 4'(i), 0, "R4");
    // R5 end pair, R6 idle after
    drive(0, 4'h0, 0, "R5");
    drive(0, 4'h0, 0, "R5");
    for (int i = 0; i < 3; i++) drive(0, 4'h9, 0, "R6");
    // R8 tx_er ignored in idle, J and K; honoured in data
    drive(0, 4'h2, 1, "R8");
    drive(1, 4'h2, 1, "R8");
    drive(1, 4'h2, 1, "R8");
    drive(1, 4'h3, 1, "R8");
    drive(1, 4'h7, 0, "R4");
    // R7 restart landing on R
    drive(0, 4'h0, 0, "R5");
    drive(1, 4'h0, 0, "R7");
    drive(1, 4'h0, 0, "R7");
    drive(1, 4'h0, 0, "R3");
    drive(1, 4'hA, 0, "R4");
    drive(0, 4'h0, 0, "R5");
    drive(0, 4'h0, 0, "R5");
    drive(0, 4'h0, 0, "R6");
    // R10 frame ends right after J
    drive(1, 4'h1, 0, "R10");
    drive(0, 4'h1, 0, "R10");
    drive(0, 4'h1, 0, "R10");
    drive(0, 4'h1, 0, "R10");
    drive(0, 4'h1, 0, "R10");
    drive(0, 4'h1, 0, "R6");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule